// File: doc/BRIEF.md
# Accumulator Machine Control Sequencer

This block is the hardwired control for a 16-bit single-accumulator processor with a 12-bit word address. A timing-state machine steps each instruction through address setup, word fetch, decode and up to four execute states. Along the way it drives the program counter, the address, instruction, data and temporary registers, and the indirect, interrupt-pending, interrupt-enable and run flip-flops. Memory is reached through a single port that is read combinationally and written on the clock edge. The accumulator and its link bit E live in a separate unit. That unit receives operation strobes, and the sequencer reads its current value back.

An instruction word holds the address in bits 11..0, the operation in bits 14..12 and the indirect flag in bit 15. Operations 0 to 6 reference memory. Operation 7 selects a register-reference group when bit 15 is 0 and an I/O group when bit 15 is 1. In both groups each low bit enables one action. Interrupt requests are not taken in the middle of an instruction. They are latched while an instruction executes and acted on at the next instruction boundary. The interrupt cycle saves the program counter at word 0, continues at word 1 and disables further interrupts.

The states are FETCH_ADDR (T0), FETCH_WORD (T1), DECODE (T2), EXEC3 to EXEC6 (T3 to T6), INTR_SAVE and INTR_VECTOR (the T1 and T2 of the interrupt cycle) and HALTED. The transitions are as follows:
- FETCH_ADDR goes to FETCH_WORD, or to INTR_SAVE when an interrupt is pending.
- FETCH_WORD goes to DECODE, and DECODE goes to EXEC3.
- EXEC3 goes to EXEC4 for a memory reference, to HALTED on halt, and otherwise back to FETCH_ADDR.
- EXEC4 goes to EXEC5 for AND, ADD, LDA, BSA and ISZ, and back to FETCH_ADDR for STA and BUN.
- EXEC5 goes to EXEC6 for ISZ, and otherwise back to FETCH_ADDR.
- EXEC6 goes to FETCH_ADDR.
- INTR_SAVE goes to INTR_VECTOR, and INTR_VECTOR goes to FETCH_ADDR.
- HALTED is held until reset.

Top module: `acc_seq_ctrl`

## Requirements
- R1: Reset leaves PC=0, AR=0 (so mem_addr=0), run flag set (running=1) and interrupts disabled (ien_out=0).
- R2: T0 copies PC to AR. T1 loads the word at AR into IR and increments PC. T2 copies IR bits 11..0 to AR and IR bit 15 to I.
- R3: For operations 0..6 with I=1, T3 replaces AR with bits 11..0 of the word at AR. With I=0, T3 leaves AR alone.
- R4: AND (op 0), ADD (op 1) and LDA (op 2) load DR from memory at T4. At T5 they drive acc_op with 1, 2 or 3 respectively and present DR on acc_operand. For ADD, the accumulator unit keeps the carry-out in E.
- R5: STA (op 3) writes ac_in to memory at AR in T4.
- R6: BUN (op 4) loads PC from AR at T4.
- R7: BSA (op 5) writes PC to memory at AR in T4, then loads PC with that address plus one at T5.
- R8: ISZ (op 6) reads the operand at T4, increments it at T5 and writes it back at T6. When the written value is zero, it also increments PC.
- R9: A register-reference instruction pulses rref_strobe at T3 with IR bits 11..0 on rref_bits. Bit 4 skips when ac_in bit 15 is 0, bit 3 skips when it is 1, bit 2 skips when ac_in is 0, and bit 1 skips when e_in is 0. A skip increments PC.
- R10: Register-reference bit 0 (halt) clears the run flag. Afterwards there are no memory writes or strobes, and PC stays constant.
- R11: In the I/O group, bit 11 pulses inp_strobe and bit 10 pulses out_strobe at T3. Bit 9 skips on fgi=1 and bit 8 skips on fgo=1. Bit 7 enables interrupts and bit 6 disables them.
- R12: The pending flag R is set in T3..T6 when interrupts are enabled and fgi or fgo is 1. With R set, T0 clears AR and copies PC to TR. T1 writes TR to word 0 and clears PC. T2 sets PC to 1 and clears the enable and R.
- R13: Instructions take 4 cycles for the register and I/O groups, 5 for STA and BUN, 6 for AND, ADD, LDA and BSA, and 7 for ISZ, whether or not indirect. The interrupt cycle takes 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory address (AR) |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| ac_in | input | 16 | Current accumulator value |
| e_in | input | 1 | Current link bit E |
| fgi | input | 1 | Input-ready flag |
| fgo | input | 1 | Output-ready flag |
| acc_op | output | 3 | Accumulator operation strobe: 0 none, 1 AND, 2 ADD, 3 load |
| acc_operand | output | 16 | Operand for acc_op (DR) |
| rref_strobe | output | 1 | Register-reference execute pulse |
| rref_bits | output | 12 | Register-reference action bits (IR 11..0) |
| inp_strobe | output | 1 | Load the accumulator from the input register and clear fgi |
| out_strobe | output | 1 | Load the output register from the accumulator and clear fgo |
| running | output | 1 | Run flag |
| ien_out | output | 1 | Interrupt enable |
| pc_out | output | 12 | Program counter |

## Verification
Each result is due at a fixed cycle counted from the start of its instruction, because T0 is the first cycle after reset or after the previous instruction. Accumulator strobes come at offset 5. STA and BSA writes come at offset 4 and ISZ write-back at offset 6. Register-reference and I/O strobes come at offset 3. The interrupt's save write comes one cycle after its T0. The bench adds up the instruction lengths of R13 along each program path to stamp every expected event with its absolute cycle, and the monitor compares the cycle stamp together with the data. A wrong skip, a wrong duration or a stray event therefore shows up as a miscompare.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR  = 4'd0,
        ST_FETCH_WORD  = 4'd1,
        ST_DECODE      = 4'd2,
        ST_EXEC3       = 4'd3,
        ST_EXEC4       = 4'd4,
        ST_EXEC5       = 4'd5,
        ST_EXEC6       = 4'd6,
        ST_INTR_SAVE   = 4'd7,
        ST_INTR_VECTOR = 4'd8,
        ST_HALTED      = 4'd9
    } seq_state_e;

    typedef enum logic [2:0] {
        ACC_NONE = 3'd0,
        ACC_AND  = 3'd1,
        ACC_ADD  = 3'd2,
        ACC_LOAD = 3'd3
    } acc_op_e;

    // operation field values
    localparam int OPC_AND = 0;
    localparam int OPC_ADD = 1;
    localparam int OPC_LDA = 2;
    localparam int OPC_STA = 3;
    localparam int OPC_BUN = 4;
    localparam int OPC_BSA = 5;
    localparam int OPC_ISZ = 6;
    localparam int OPC_EXT = 7;

    // action bit positions inside the low field
    localparam int RB_SPA = 4;
    localparam int RB_SNA = 3;
    localparam int RB_SZA = 2;
    localparam int RB_SZE = 1;
    localparam int RB_HLT = 0;
    localparam int IB_INP = 11;
    localparam int IB_OUT = 10;
    localparam int IB_SKI = 9;
    localparam int IB_SKO = 8;
    localparam int IB_ION = 7;
    localparam int IB_IOF = 6;

endpackage

// File: rtl/acc_seq_opdecode.sv
module acc_seq_opdecode #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic [DATA_W-1:0] ir,
    output logic [7:0]        op_onehot,
    output logic              mem_ref,
    output logic              reg_ref,
    output logic              io_ref
);
    localparam int OPC_LSB = ADDR_W;
    localparam int IND_BIT = DATA_W - 1;

    logic [2:0] opcode;
    assign opcode = ir[OPC_LSB +: 3];

    for (genvar g = 0; g < 8; g++) begin : g_onehot
        assign op_onehot[g] = (opcode == 3'(g));
    end

    assign mem_ref = ~op_onehot[acc_seq_pkg::OPC_EXT];
    assign reg_ref = op_onehot[acc_seq_pkg::OPC_EXT] & ~ir[IND_BIT];
    assign io_ref  = op_onehot[acc_seq_pkg::OPC_EXT] &  ir[IND_BIT];
endmodule

// File: rtl/acc_seq_skip.sv
module acc_seq_skip #(
    parameter int DATA_W = 16
) (
    input  logic              reg_ref,
    input  logic              io_ref,
    input  logic              b_spa,
    input  logic              b_sna,
    input  logic              b_sza,
    input  logic              b_sze,
    input  logic              b_ski,
    input  logic              b_sko,
    input  logic [DATA_W-1:0] ac,
    input  logic              e,
    input  logic              fgi,
    input  logic              fgo,
    output logic              skip
);
    logic ac_neg, ac_zero, reg_skip, io_skip;

    assign ac_neg   = ac[DATA_W-1];
    assign ac_zero  = (ac == '0);
    assign reg_skip = (b_spa & ~ac_neg) | (b_sna & ac_neg) | (b_sza & ac_zero) | (b_sze & ~e);
    assign io_skip  = (b_ski & fgi) | (b_sko & fgo);
    assign skip     = (reg_ref & reg_skip) | (io_ref & io_skip);
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] ac_in,
    input  logic              e_in,
    input  logic              fgi,
    input  logic              fgo,
    output logic [2:0]        acc_op,
    output logic [DATA_W-1:0] acc_operand,
    output logic              rref_strobe,
    output logic [ADDR_W-1:0] rref_bits,
    output logic              inp_strobe,
    output logic              out_strobe,
    output logic              running,
    output logic              ien_out,
    output logic [ADDR_W-1:0] pc_out
);
    localparam int IND_BIT = DATA_W - 1;
    localparam int PAD_W   = DATA_W - ADDR_W;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pc_q, ar_q, tr_q;
    logic [DATA_W-1:0] ir_q, dr_q;
    logic              i_q, r_q, ien_q, s_q;

    logic [7:0] op_oh;
    logic       mem_ref, reg_ref, io_ref, skip;
    logic       exec_phase;

    acc_seq_opdecode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .ir        (ir_q),
        .op_onehot (op_oh),
        .mem_ref   (mem_ref),
        .reg_ref   (reg_ref),
        .io_ref    (io_ref)
    );

    acc_seq_skip #(.DATA_W(DATA_W)) u_skip (
        .reg_ref (reg_ref),
        .io_ref  (io_ref),
        .b_spa   (ir_q[RB_SPA]),
        .b_sna   (ir_q[RB_SNA]),
        .b_sza   (ir_q[RB_SZA]),
        .b_sze   (ir_q[RB_SZE]),
        .b_ski   (ir_q[IB_SKI]),
        .b_sko   (ir_q[IB_SKO]),
        .ac      (ac_in),
        .e       (e_in),
        .fgi     (fgi),
        .fgo     (fgo),
        .skip    (skip)
    );

    assign exec_phase  = (state_q == ST_EXEC3) || (state_q == ST_EXEC4) ||
                         (state_q == ST_EXEC5) || (state_q == ST_EXEC6);
    assign mem_addr    = ar_q;
    assign acc_operand = dr_q;
    assign rref_bits   = ir_q[ADDR_W-1:0];
    assign running     = s_q;
    assign ien_out     = ien_q;
    assign pc_out      = pc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FETCH_ADDR;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        mem_we      = 1'b0;
        mem_wdata   = '0;
        acc_op      = ACC_NONE;
        rref_strobe = 1'b0;
        inp_strobe  = 1'b0;
        out_strobe  = 1'b0;
        unique case (state_q)
            ST_FETCH_ADDR:  state_d = r_q ? ST_INTR_SAVE : ST_FETCH_WORD;
            ST_FETCH_WORD:  state_d = ST_DECODE;
            ST_DECODE:      state_d = ST_EXEC3;
            ST_EXEC3: begin
                rref_strobe = reg_ref;
                inp_strobe  = io_ref & ir_q[IB_INP];
                out_strobe  = io_ref & ir_q[IB_OUT];
                if (mem_ref)                      state_d = ST_EXEC4;
                else if (reg_ref && ir_q[RB_HLT]) state_d = ST_HALTED;
                else                              state_d = ST_FETCH_ADDR;
            end
            ST_EXEC4: begin
                if (op_oh[OPC_STA]) begin
                    mem_we    = 1'b1;
                    mem_wdata = ac_in;
                end
                if (op_oh[OPC_BSA]) begin
                    mem_we    = 1'b1;
                    mem_wdata = {{PAD_W{1'b0}}, pc_q};
                end
                state_d = (op_oh[OPC_STA] || op_oh[OPC_BUN]) ? ST_FETCH_ADDR : ST_EXEC5;
            end
            ST_EXEC5: begin
                if (op_oh[OPC_AND]) acc_op = ACC_AND;
                if (op_oh[OPC_ADD]) acc_op = ACC_ADD;
                if (op_oh[OPC_LDA]) acc_op = ACC_LOAD;
                state_d = op_oh[OPC_ISZ] ? ST_EXEC6 : ST_FETCH_ADDR;
            end
            ST_EXEC6: begin
                mem_we    = 1'b1;
                mem_wdata = dr_q;
                state_d   = ST_FETCH_ADDR;
            end
            ST_INTR_SAVE: begin
                mem_we    = 1'b1;
                mem_wdata = {{PAD_W{1'b0}}, tr_q};
                state_d   = ST_INTR_VECTOR;
            end
            ST_INTR_VECTOR: state_d = ST_FETCH_ADDR;
            ST_HALTED:      state_d = ST_HALTED;
            default:        state_d = ST_FETCH_ADDR;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ar_q  <= '0;
            tr_q  <= '0;
            ir_q  <= '0;
            dr_q  <= '0;
            i_q   <= 1'b0;
            r_q   <= 1'b0;
            ien_q <= 1'b0;
            s_q   <= 1'b1;
        end else begin
            if (exec_phase && ien_q && (fgi || fgo)) r_q <= 1'b1;
            unique case (state_q)
                ST_FETCH_ADDR: begin
                    if (r_q) begin
                        ar_q <= '0;
                        tr_q <= pc_q;
                    end else begin
                        ar_q <= pc_q;
                    end
                end
                ST_FETCH_WORD: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + 1'b1;
                end
                ST_DECODE: begin
                    ar_q <= ir_q[ADDR_W-1:0];
                    i_q  <= ir_q[IND_BIT];
                end
                ST_EXEC3: begin
                    if (mem_ref && i_q)               ar_q  <= mem_rdata[ADDR_W-1:0];
                    if (skip)                         pc_q  <= pc_q + 1'b1;
                    if (reg_ref && ir_q[RB_HLT])      s_q   <= 1'b0;
                    if (io_ref && ir_q[IB_ION])       ien_q <= 1'b1;
                    if (io_ref && ir_q[IB_IOF])       ien_q <= 1'b0;
                end
                ST_EXEC4: begin
                    if (op_oh[OPC_AND] || op_oh[OPC_ADD] || op_oh[OPC_LDA] || op_oh[OPC_ISZ])
                        dr_q <= mem_rdata;
                    if (op_oh[OPC_BUN]) pc_q <= ar_q;
                    if (op_oh[OPC_BSA]) ar_q <= ar_q + 1'b1;
                end
                ST_EXEC5: begin
                    if (op_oh[OPC_BSA]) pc_q <= ar_q;
                    if (op_oh[OPC_ISZ]) dr_q <= dr_q + 1'b1;
                end
                ST_EXEC6: begin
                    if (dr_q == '0) pc_q <= pc_q + 1'b1;
                end
                ST_INTR_SAVE:   pc_q <= '0;
                ST_INTR_VECTOR: begin
                    pc_q  <= pc_q + 1'b1;
                    ien_q <= 1'b0;
                    r_q   <= 1'b0;
                end
                ST_HALTED: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_seq_ctrl_chk.sv
module acc_seq_ctrl_chk
    import acc_seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_e        state_q,
    input logic [ADDR_W-1:0] pc_q,
    input logic [ADDR_W-1:0] ar_q,
    input logic [ADDR_W-1:0] tr_q,
    input logic [DATA_W-1:0] ir_q,
    input logic              r_q,
    input logic              ien_q,
    input logic              s_q,
    input logic              mem_we,
    input logic [2:0]        acc_op,
    input logic              rref_strobe,
    input logic              inp_strobe,
    input logic              out_strobe
);
    assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_WORD) |=> (pc_q == $past(pc_q) + 1'b1));

    assert_decode_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (ar_q == $past(ir_q[ADDR_W-1:0])));

    assert_acc_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_op != 3'd0) |-> (state_q == ST_EXEC5));

    assert_rref_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rref_strobe |-> (state_q == ST_EXEC3 && !inp_strobe && !out_strobe));

    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q |=> (!s_q && $stable(pc_q) && !mem_we));

    assert_write_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> s_q);

    assert_int_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_ADDR && r_q) |=> (ar_q == '0 && tr_q == $past(pc_q)));

    assert_int_vector_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTR_VECTOR) |=> (pc_q == ADDR_W'(1) && !ien_q && !r_q));
endmodule

bind acc_seq_ctrl acc_seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .pc_q        (pc_q),
    .ar_q        (ar_q),
    .tr_q        (tr_q),
    .ir_q        (ir_q),
    .r_q         (r_q),
    .ien_q       (ien_q),
    .s_q         (s_q),
    .mem_we      (mem_we),
    .acc_op      (acc_op),
    .rref_strobe (rref_strobe),
    .inp_strobe  (inp_strobe),
    .out_strobe  (out_strobe)
);

// File: tb/acc_seq_ctrl_tb.sv
module acc_seq_ctrl_tb;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int EV_WR = 1, EV_ACC = 2, EV_RREF = 3, EV_INP = 4, EV_OUT = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata, mem_wdata;
    logic          mem_we;
    logic [DW-1:0] ac_in = '0;
    logic          e_in = 1'b0, fgi = 1'b0, fgo = 1'b0;
    logic [2:0]    acc_op;
    logic [DW-1:0] acc_operand;
    logic          rref_strobe, inp_strobe, out_strobe, running, ien_out;
    logic [AW-1:0] rref_bits, pc_out;

    always #10 clk = ~clk;

    acc_seq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .ac_in(ac_in), .e_in(e_in),
        .fgi(fgi), .fgo(fgo), .acc_op(acc_op), .acc_operand(acc_operand),
        .rref_strobe(rref_strobe), .rref_bits(rref_bits), .inp_strobe(inp_strobe),
        .out_strobe(out_strobe), .running(running), .ien_out(ien_out), .pc_out(pc_out)
    );

    // memory model: combinational read, one writer process
    logic [DW-1:0] mem [0:(1<<AW)-1];
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (ld_en)       mem[ld_addr]  <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    logic mon_on = 1'b0;

    typedef struct {
        int    cyc;
        int    kind;
        int    a;
        int    d;
        string req;
    } ev_t;
    ev_t exp_q[$];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic push_ev(input int c, input int k, input int a, input int d, input string req);
        ev_t e;
        e.cyc = c; e.kind = k; e.a = a; e.d = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int k, input int a, input int d);
        ev_t e;
        vectors++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected event: kind=%0d a=%0h d=%0h cyc=%0d expected none", k, a, d, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.a != a || e.d != d || e.cyc != cyc) begin
                errors++;
                $display("FAIL %s: actual kind=%0d a=%0h d=%0h cyc=%0d expected kind=%0d a=%0h d=%0h cyc=%0d",
                         e.req, k, a, d, cyc, e.kind, e.a, e.d, e.cyc);
            end
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (mem_we)         observe(EV_WR, int'(mem_addr), int'(mem_wdata));
            if (acc_op != 3'd0) observe(EV_ACC, int'(acc_op), int'(acc_operand));
            if (rref_strobe)    observe(EV_RREF, int'(rref_bits), 0);
            if (inp_strobe)     observe(EV_INP, 0, 0);
            if (out_strobe)     observe(EV_OUT, 0, 0);
        end
    end

    task automatic check(input int act, input int expv, input string what);
        vectors++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    task automatic poke(input int a, input int d);
        ld_en = 1'b1; ld_addr = AW'(a); ld_data = DW'(d);
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    task automatic begin_test();
        rst_n = 1'b0; mon_on = 1'b0;
        exp_q.delete();
        for (int i = 0; i < (1 << AW); i++) poke(i, 0);
    endtask

    task automatic release_reset();
        @(posedge clk); #2;
        rst_n = 1'b1; mon_on = 1'b1;
    endtask

    task automatic finish_test(input int exp_pc, input int exp_ien, input string req);
        for (int n = 0; n < 400 && running; n++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(int'(running), 0, "R10 run flag cleared by halt");
        check(int'(pc_out), exp_pc, {req, " final PC"});
        check(int'(ien_out), exp_ien, {req, " final interrupt enable"});
        while (exp_q.size() > 0) begin
            ev_t e;
            e = exp_q.pop_front();
            vectors++; errors++;
            $display("FAIL %s: actual missing event expected kind=%0d a=%0h d=%0h cyc=%0d",
                     e.req, e.kind, e.a, e.d, e.cyc);
        end
        mon_on = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : driver
        int t;
        // ---------- program A: memory reference ----------
        begin_test();
        ac_in = 16'h1234; e_in = 1'b0; fgi = 1'b0; fgo = 1'b0;
        poke(0, 16'h2100); poke(1, 16'h1101); poke(2, 16'h8102); poke(3, 16'h3104);
        poke(4, 16'h4006); poke(5, 16'h7001); poke(6, 16'h5200); poke(7, 16'h6105);
        poke(8, 16'h7001); poke(9, 16'h6106); poke(10, 16'h7001);
        poke(16'h100, 16'h0F0F); poke(16'h101, 16'h1111); poke(16'h102, 16'h0103);
        poke(16'h103, 16'h00FF); poke(16'h105, 16'hFFFF); poke(16'h106, 16'h0005);
        poke(16'h201, 16'hC200);
        t = 0;
        push_ev(t + 5, EV_ACC, 3, 16'h0F0F, "R4 LDA"); t += 6;
        push_ev(t + 5, EV_ACC, 2, 16'h1111, "R4 ADD"); t += 6;
        push_ev(t + 5, EV_ACC, 1, 16'h00FF, "R3 indirect AND"); t += 6;
        push_ev(t + 4, EV_WR, 16'h104, 16'h1234, "R5 STA"); t += 5;
        t += 5; // R6 BUN to 6
        push_ev(t + 4, EV_WR, 16'h200, 7, "R7 BSA return save"); t += 6;
        t += 5; // R3 indirect BUN back to 7
        push_ev(t + 6, EV_WR, 16'h105, 0, "R8 ISZ wrap"); t += 7;
        push_ev(t + 6, EV_WR, 16'h106, 6, "R8 ISZ no skip"); t += 7;
        push_ev(t + 3, EV_RREF, 16'h001, 0, "R13 halt timing");
        release_reset();
        #1;
        check(int'(pc_out), 0, "R1 reset PC");
        check(int'(mem_addr), 0, "R1 reset AR");
        check(int'(running), 1, "R1 reset run flag");
        check(int'(ien_out), 0, "R1 reset interrupt enable");
        finish_test(11, 0, "R2 R6 program A");

        // ---------- program B: register and I/O groups ----------
        begin_test();
        ac_in = 16'h8000; e_in = 1'b0; fgi = 1'b0; fgo = 1'b1;
        poke(0, 16'h7010); poke(1, 16'h7008); poke(2, 16'h7800); poke(3, 16'h7002);
        poke(4, 16'h7800); poke(5, 16'h7004); poke(6, 16'hF800); poke(7, 16'hF400);
        poke(8, 16'hF200); poke(9, 16'hF100); poke(10, 16'h7800); poke(11, 16'h7001);
        t = 0;
        push_ev(t + 3, EV_RREF, 16'h010, 0, "R9 SPA negative no skip"); t += 4;
        push_ev(t + 3, EV_RREF, 16'h008, 0, "R9 SNA skip"); t += 4;
        push_ev(t + 3, EV_RREF, 16'h002, 0, "R9 SZE skip"); t += 4;
        push_ev(t + 3, EV_RREF, 16'h004, 0, "R9 SZA nonzero no skip"); t += 4;
        push_ev(t + 3, EV_INP, 0, 0, "R11 INP strobe"); t += 4;
        push_ev(t + 3, EV_OUT, 0, 0, "R11 OUT strobe"); t += 4;
        t += 4; // R11 SKI with fgi=0
        t += 4; // R11 SKO with fgo=1 skips
        push_ev(t + 3, EV_RREF, 16'h001, 0, "R11 skip path halt");
        release_reset();
        finish_test(12, 0, "R11 program B");

        // ---------- program C: interrupt cycle ----------
        begin_test();
        ac_in = 16'h0001; e_in = 1'b0; fgi = 1'b1; fgo = 1'b0;
        poke(0, 16'hF080); poke(1, 16'h7800); poke(2, 16'h7001);
        t = 0;
        t += 4; // ION
        push_ev(t + 3, EV_RREF, 16'h800, 0, "R12 CLA before interrupt"); t += 4;
        push_ev(t + 1, EV_WR, 0, 2, "R12 interrupt saves PC at word 0"); t += 3;
        push_ev(t + 3, EV_RREF, 16'h800, 0, "R12 resume at word 1"); t += 4;
        push_ev(t + 3, EV_RREF, 16'h001, 0, "R12 halt after resume");
        release_reset();
        finish_test(3, 0, "R12 program C");

        // ---------- program D: enable ----------
        begin_test();
        ac_in = 16'h0000; fgi = 1'b0; fgo = 1'b0;
        poke(0, 16'hF080); poke(1, 16'h7001);
        push_ev(7, EV_RREF, 16'h001, 0, "R11 ION then halt");
        release_reset();
        finish_test(2, 1, "R11 ION program D");

        // ---------- program E: enable then disable ----------
        begin_test();
        poke(0, 16'hF080); poke(1, 16'hF040); poke(2, 16'h7001);
        push_ev(11, EV_RREF, 16'h001, 0, "R11 IOF then halt");
        release_reset();
        finish_test(3, 0, "R11 IOF program E");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule